// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This block is a watchdog that software must keep feeding to hold off a system reset. It leaves reset switched off. Software switches it on, and later restarts its count, by writing a fixed pair of byte values to one write-only register address. Once it is on, it advances by one on every machine cycle in which counting is allowed. If software stops feeding it, the count reaches its terminal value and the block drives a reset pulse of fixed length. Only a hardware reset or its own overflow can switch it off again.

Counting is paused in several cases. It pauses when the machine-cycle enable is low, when the oscillator is reported stopped, and while the hold that follows a power-down wake-up is asserted. It can also pause during idle, depending on a configuration bit. The counter value cannot be read or written. The key register is the only point of contact with software.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset and after any later reset, `wdt_rst_o` is low and the watchdog is disarmed: with no key written, no pulse appears for more than 2^CNT_W cycles.
- R2: A write of 0x1E to address 0xA6, followed by the next write to 0xA6 carrying 0xE1, arms the watchdog with its count at zero.
- R3: A write of 0xE1 to 0xA6 is ignored unless the previous write to 0xA6 was 0x1E. Any value other than 0x1E or 0xE1 written to 0xA6 is ignored, and it clears a pending 0x1E. Key pairs written to other addresses do nothing.
- R4: Writing the key pair again while armed restarts the count from zero.
- R5: When armed, the count advances only in cycles where both `mc_en` and `osc_run` are high.
- R6: When `idle` is high, the count holds if `idle_freeze` is 1 and keeps advancing if it is 0.
- R7: While `pd_hold` is high, the count holds, and it resumes when `pd_hold` falls.
- R8: Once armed, the 2^CNT_W-1'th advance since arming or servicing is an overflow, and `wdt_rst_o` rises in the cycle after that advance.
- R9: Each pulse stays high for exactly PULSE_LEN clock cycles.
- R10: No register write can disarm the watchdog; an armed watchdog that is not serviced always overflows.
- R11: An overflow disarms the watchdog. While the pulse is high, all key writes are ignored and a pending 0x1E is dropped, so the watchdog is still disarmed after the pulse.
- R12: When a completed key pair lands in the same cycle as the overflowing advance, the service wins and no pulse is produced.
- R13: Writes to addresses other than 0xA6 do not disturb a pending 0x1E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-period clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_stb | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| mc_en | input | 1 | High in the clock cycle that ends a machine cycle |
| osc_run | input | 1 | Oscillator running status |
| idle | input | 1 | Idle mode indication |
| idle_freeze | input | 1 | 1 = hold the count while in idle |
| pd_hold | input | 1 | Hold the count after a power-down wake-up until the wake pin returns high |
| wdt_rst_o | output | 1 | Active-high watchdog reset pulse |

## Verification
The assertions assume that every input is synchronous to `clk` and changes only between rising edges. They also assume that a write is a single-cycle strobe, with address and data valid in the same cycle. The bench drives every input on the falling edge and holds each write for exactly one rising edge, so these conditions always hold. The gating inputs are changed only while the count is close to its terminal value. In that position a hold that failed to take effect would show up as an early pulse at the output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Classification of one register write as seen by the key sequencer
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_FIRST  = 2'd1,
        EV_SECOND = 2'd2,
        EV_OTHER  = 2'd3
    } key_ev_e;

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              unlock
);

    typedef struct packed {
        logic half;
    } ks_t;

    ks_t     ks_d, ks_q;
    key_ev_e ev;

    always_comb begin
        ev = EV_NONE;
        if (wr_stb && !blank && (wr_addr == KEY_ADDR)) begin
            if (wr_data == KEY_FIRST)       ev = EV_FIRST;
            else if (wr_data == KEY_SECOND) ev = EV_SECOND;
            else                            ev = EV_OTHER;
        end

        ks_d   = ks_q;
        unlock = 1'b0;
        if (blank) begin
            ks_d.half = 1'b0;
        end else begin
            case (ev)
                EV_FIRST:  ks_d.half = 1'b1;
                EV_SECOND: begin
                    unlock    = ks_q.half;
                    ks_d.half = 1'b0;
                end
                EV_OTHER:  ks_d.half = 1'b0;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ks_q <= '0;
        else        ks_q <= ks_d;
    end

endmodule

// File: rtl/wdt_tick_count.sv
module wdt_tick_count #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank,
    input  logic             unlock,
    input  logic             mc_en,
    input  logic             osc_run,
    input  logic             idle,
    input  logic             idle_freeze,
    input  logic             pd_hold,
    output logic             armed,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] NEAR = TERM - 1'b1;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } cs_t;

    cs_t  cs_d, cs_q;
    logic adv;

    always_comb begin
        adv  = cs_q.en && mc_en && osc_run && !(idle && idle_freeze) && !pd_hold;
        cs_d = cs_q;
        ovf  = 1'b0;
        if (blank) begin
            cs_d.en  = 1'b0;
            cs_d.cnt = '0;
        end else if (unlock) begin
            cs_d.en  = 1'b1;
            cs_d.cnt = '0;
        end else if (adv) begin
            if (cs_q.cnt == NEAR) begin
                ovf      = 1'b1;
                cs_d.en  = 1'b0;
                cs_d.cnt = '0;
            end else begin
                cs_d.cnt = cs_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign armed = cs_q.en;
    assign count = cs_q.cnt;

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);

    localparam int            PW  = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

    typedef struct packed {
        logic [PW-1:0] left;
    } ps_t;

    ps_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (fire)                 ps_d.left = LEN;
        else if (ps_q.left != '0) ps_d.left = ps_q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign active = (ps_q.left != '0);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1,
    parameter int                CNT_W      = 14,
    parameter int                PULSE_LEN  = 98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mc_en,
    input  logic              osc_run,
    input  logic              idle,
    input  logic              idle_freeze,
    input  logic              pd_hold,
    output logic              wdt_rst_o
);

    logic             unlock;
    logic             armed;
    logic [CNT_W-1:0] count;
    logic             ovf;
    logic             pulse_on;

    wdt_key_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .KEY_ADDR  (KEY_ADDR),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .blank  (pulse_on),
        .wr_stb (wr_stb),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .unlock (unlock)
    );

    wdt_tick_count #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .blank      (pulse_on),
        .unlock     (unlock),
        .mc_en      (mc_en),
        .osc_run    (osc_run),
        .idle       (idle),
        .idle_freeze(idle_freeze),
        .pd_hold    (pd_hold),
        .armed      (armed),
        .count      (count),
        .ovf        (ovf)
    );

    wdt_rst_pulse #(
        .PULSE_LEN(PULSE_LEN)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (ovf),
        .active(pulse_on)
    );

    assign wdt_rst_o = pulse_on;

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
    parameter int CNT_W     = 14,
    parameter int PULSE_LEN = 98
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mc_en,
    input logic             osc_run,
    input logic             idle,
    input logic             idle_freeze,
    input logic             pd_hold,
    input logic             unlock,
    input logic             armed,
    input logic [CNT_W-1:0] count,
    input logic             ovf,
    input logic             wdt_rst_o
);

    int unsigned hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_run <= 0;
        else if (wdt_rst_o) hi_run <= hi_run + 1;
        else                hi_run <= 0;
    end

    AST_KEY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> (armed && count == '0)); // R2

    AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && unlock) |=> (count == '0) && !wdt_rst_o); // R4

    AST_GATED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mc_en && osc_run && !(idle && idle_freeze) && !pd_hold && !unlock && !ovf)
        |=> (count == $past(count) + 1'b1)); // R5

    AST_NO_STEP_WITHOUT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !(mc_en && osc_run) && !unlock) |=> $stable(count)); // R5

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && idle && idle_freeze && !unlock) |=> $stable(count)); // R6

    AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pd_hold && !unlock) |=> $stable(count)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count != {CNT_W{1'b1}}); // R8

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> wdt_rst_o); // R8

    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> (hi_run < PULSE_LEN)); // R9

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_o) |-> (hi_run == PULSE_LEN)); // R9

    AST_STAYS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ovf) |=> armed); // R10

    AST_DISARM_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !armed); // R11

    AST_PULSE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> (!armed && !unlock)); // R11

endmodule

bind keyed_watchdog keyed_watchdog_chk #(
    .CNT_W    (CNT_W),
    .PULSE_LEN(PULSE_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mc_en      (mc_en),
    .osc_run    (osc_run),
    .idle       (idle),
    .idle_freeze(idle_freeze),
    .pd_hold    (pd_hold),
    .unlock     (unlock),
    .armed      (armed),
    .count      (count),
    .ovf        (ovf),
    .wdt_rst_o  (wdt_rst_o)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 10;
    localparam int PL         = 98;
    localparam int LAST       = (1 << CW) - 1;
    localparam int LIMIT      = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       mc_en = 1'b1;
    logic       osc_run = 1'b1;
    logic       idle = 1'b0;
    logic       idle_freeze = 1'b0;
    logic       pd_hold = 1'b0;
    logic       wdt_rst_o;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    keyed_watchdog #(.CNT_W(CW), .PULSE_LEN(PL)) u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .mc_en(mc_en), .osc_run(osc_run), .idle(idle),
        .idle_freeze(idle_freeze), .pd_hold(pd_hold), .wdt_rst_o(wdt_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: enabled flag, count, pending first key, pulse cycles left
    int r_en, r_cnt, r_pend, r_left;

    always @(posedge clk or negedge rst_n) begin : ref_model
        bit hit, ok, adv;
        if (!rst_n) begin
            r_en = 0; r_cnt = 0; r_pend = 0; r_left = 0;
        end else begin
            adv = (r_en != 0) && mc_en && osc_run && !(idle && idle_freeze) && !pd_hold;
            if (r_left > 0) begin
                r_left = r_left - 1;
                r_en = 0; r_cnt = 0; r_pend = 0;
            end else begin
                hit = wr_stb && (wr_addr == 8'hA6);
                ok  = hit && (wr_data == 8'hE1) && (r_pend != 0);
                if (hit) r_pend = (wr_data == 8'h1E) ? 1 : 0;
                if (ok) begin
                    r_en = 1; r_cnt = 0;
                end else if (adv) begin
                    if (r_cnt == LAST - 1) begin
                        r_en = 0; r_cnt = 0; r_left = PL;
                    end else begin
                        r_cnt = r_cnt + 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (wdt_rst_o !== (r_left > 0)) begin
                n_fail++;
                $display("FAIL %s (cycle model): actual %0b expected %0b", cur_req, wdt_rst_o, (r_left > 0));
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a falling edge; the write is taken on the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic arm();
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'hE1);
    endtask

    task automatic wait_pulse(input int limit, output int n);
        n = 0;
        while (!wdt_rst_o && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_low();
        while (wdt_rst_o) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        n_fail++;
        $display("FAIL %s watchdog expired: actual running expected finished", cur_req);
        finish_run();
    end

    initial begin
        int n;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset, no pulse without a key
        cur_req = "R1";
        chk("R1", wdt_rst_o, 0);
        tick(LAST + 50);
        chk("R1", wdt_rst_o, 0);

        // R3: rejected key sequences
        cur_req = "R3";
        wr(8'hA6, 8'hE1);
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
        wr(8'hA5, 8'h1E); wr(8'hA5, 8'hE1);
        wr(8'hA6, 8'hE1);
        tick(LAST + 50);
        chk("R3", wdt_rst_o, 0);

        // R13 + R2 + R8: other-address write between keys, exact latency
        cur_req = "R8";
        wr(8'hA6, 8'h1E); wr(8'h30, 8'h99); wr(8'hA6, 8'hE1);
        wait_pulse(LAST + 200, n);
        chk("R13", wdt_rst_o, 1);
        chk("R8", n, LAST);

        // R9 + R11: width, keys ignored during pulse
        cur_req = "R11";
        w = 0;
        wr(8'hA6, 8'h1E); w++;
        wr(8'hA6, 8'hE1); w++;
        while (wdt_rst_o) begin @(negedge clk); w++; end
        chk("R9", w, PL);
        tick(LAST + 50);
        chk("R11", wdt_rst_o, 0);

        // R2 + R4 + R10
        cur_req = "R4";
        arm();
        tick(LAST - 100);
        arm();
        tick(LAST - 100);
        chk("R4", wdt_rst_o, 0);
        cur_req = "R10";
        wr(8'hA6, 8'h00); wr(8'hA6, 8'hFF); wr(8'hA6, 8'hE1); wr(8'h20, 8'h00);
        wait_pulse(LAST + 200, n);
        chk("R10", wdt_rst_o, 1);
        chk("R2", n <= 200 ? 1 : 0, 1);
        wait_low();

        // R5: machine-cycle enable and oscillator status
        cur_req = "R5";
        arm();
        tick(LAST - 20);
        mc_en = 1'b0; tick(200);
        chk("R5", wdt_rst_o, 0);
        mc_en = 1'b1; osc_run = 1'b0; tick(200);
        chk("R5", wdt_rst_o, 0);
        osc_run = 1'b1;
        n = 0;
        while (!wdt_rst_o && n < 200) begin
            mc_en = ~mc_en;
            @(negedge clk);
            n++;
        end
        mc_en = 1'b1;
        chk("R5", wdt_rst_o, 1);
        wait_low();

        // R6: idle with and without freeze
        cur_req = "R6";
        arm();
        tick(LAST - 20);
        idle = 1'b1; idle_freeze = 1'b1; tick(200);
        chk("R6", wdt_rst_o, 0);
        idle_freeze = 1'b0;
        wait_pulse(200, n);
        chk("R6", wdt_rst_o, 1);
        chk("R6", n <= 22 ? 1 : 0, 1);
        idle = 1'b0;
        wait_low();

        // R7: power-down exit hold
        cur_req = "R7";
        arm();
        tick(LAST - 20);
        pd_hold = 1'b1; tick(200);
        chk("R7", wdt_rst_o, 0);
        pd_hold = 1'b0;
        wait_pulse(200, n);
        chk("R7", wdt_rst_o, 1);
        wait_low();

        // R12: service on the overflowing cycle wins
        cur_req = "R12";
        arm();
        tick(LAST - 2);
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'hE1);
        chk("R12", wdt_rst_o, 0);
        wait_pulse(LAST + 200, n);
        chk("R12", n, LAST);
        wait_low();

        // R1: reset while armed disarms
        cur_req = "R1";
        arm();
        tick(100);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", wdt_rst_o, 0);
        rst_n = 1'b1;
        tick(LAST + 50);
        chk("R1", wdt_rst_o, 0);

        finish_run();
    end

endmodule